// File: doc/BRIEF.md
# Dual-Bank Interrupt Event Controller

The block gathers interrupt notifications from device sources and DMA sources into two 32-bit banks. Each bank keeps a register of latched events, a mask and a register of current line levels. A source reports a change on its line by presenting a source ID word and the new line state for one cycle. The block sends that ID to bank 1 or bank 2, according to the range the ID falls in. It then latches the masked event and updates the level. The single CPU interrupt line is high whenever any event bit in either bank is set.

Software uses a 32-bit register port with a write strobe and a combinational read. The bus is little-endian, so every written word is byte-reversed before it reaches the banks, and every readback is byte-reversed on its way out. Bit 31 of the bank-1 mask, in the reversed domain, enables the emulated interrupt scheme. Source notifications take effect only while that bit is set. The same bit also arms a clear-all command on the bank-1 clear register.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset, all event, mask and level registers read as zero and `irq_o` is low.
- R2: A written word is byte-reversed before use: raw byte 3 becomes bits 7:0 and raw byte 0 becomes bits 31:24. Event, mask and level registers read back byte-reversed. Clear registers read as zero. Byte offsets: 0x00 bank-2 events, 0x04 bank-2 mask, 0x08 bank-2 clear, 0x0C bank-2 levels, 0x10 bank-1 events, 0x14 bank-1 mask, 0x18 bank-1 clear, 0x1C bank-1 levels.
- R3: A write to the bank-1 mask replaces that mask. It also copies reversed bit 31 (the mode bit) into bit 31 of the bank-2 mask.
- R4: A write to the bank-2 mask ORs reversed bits 30..0 into that mask and leaves bit 31 of that mask unchanged.
- R5: A device ID of 2^20 or more is shifted right by 10 and applied to bank 2. A smaller device ID is applied to bank 1 unshifted.
- R6: A DMA ID of 2^10 or more is shifted right by 10 and applied to bank 2. A smaller DMA ID is applied to bank 1 unshifted.
- R7: A notification ORs its bits into the bank's events, and then the whole event register of that bank is ANDed with that bank's mask.
- R8: A notification sets the addressed level bits when the line state is 1 and clears them when it is 0.
- R9: While the mode bit is 0, notifications change neither events nor levels.
- R10: A write to the bank-2 clear register clears the bank-2 event bits that are set in reversed bits 30..0.
- R11: A write to the bank-1 clear register clears both banks' events when the mode bit is 1 and raw bit 31 of the written word is 1. In every other case it clears the bank-1 event bits that are set in reversed bits 30..0.
- R12: `irq_o` equals the OR of all event bits of both banks. It changes in the cycle after the update that caused the change.
- R13: Within one cycle, the device notification is applied first and the DMA notification second, so the DMA line state wins on a shared level bit. A clear or mask write in the same cycle acts after both, which means a clear overrides a same-cycle event and the mask that filters the events is the one from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Write data, little-endian |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| dev_vld_i | input | 1 | Device line-change notification |
| dev_id_i | input | 32 | Device source ID bits |
| dev_lvl_i | input | 1 | New device line state |
| dma_vld_i | input | 1 | DMA line-change notification |
| dma_id_i | input | 32 | DMA source ID bits |
| dma_lvl_i | input | 1 | New DMA line state |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The cases that are hardest to reach from the ports are the ones where several actions land in the same cycle: a notification together with a clear of the same bit, a notification together with a mask rewrite, and a device and a DMA notification that both hit one level bit. The bench drives these combinations in a single cycle and compares the result with the ordering set by R13.

A second hard case is the clear-all flag. It is raw bit 31, which becomes bit 7 after the byte swap. To see both outcomes, the bench fills the events while the mode bit is set, then drops the mode bit by rewriting the bank-1 mask. This leaves the events in place, so the same raw word can be shown to clear only bank-1 bit 7 when the mode bit is 0.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned NBANK = 2;

  typedef enum logic [1:0] {
    RK_EVT  = 2'd0,
    RK_MASK = 2'd1,
    RK_CLR  = 2'd2,
    RK_LVL  = 2'd3
  } reg_kind_e;

  function automatic logic [REG_W-1:0] bswap32(input logic [REG_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/irq_src_route.sv
module irq_src_route import irq_evt_pkg::*; #(
  parameter int unsigned SPLIT_LOG2 = 20,
  parameter int unsigned HI_SHIFT   = 10
) (
  input  logic                         vld_i,
  input  logic [REG_W-1:0]             id_i,
  output logic [NBANK-1:0]             bank_vld_o,
  output logic [NBANK-1:0][REG_W-1:0]  bank_bits_o
);
  logic hi;
  assign hi = (id_i[REG_W-1:SPLIT_LOG2] != '0);

  assign bank_vld_o[0]  = vld_i & ~hi;
  assign bank_vld_o[1]  = vld_i & hi;
  assign bank_bits_o[0] = id_i;
  assign bank_bits_o[1] = id_i >> HI_SHIFT;
endmodule

// File: rtl/irq_bank.sv
module irq_bank import irq_evt_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_vld_i,
  input  logic [REG_W-1:0] a_bits_i,
  input  logic             a_lvl_i,
  input  logic             b_vld_i,
  input  logic [REG_W-1:0] b_bits_i,
  input  logic             b_lvl_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] mask_d_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] clr_bits_i,
  input  logic             clr_all_i,
  output logic [REG_W-1:0] evt_o,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] lvl_o
);
  logic [REG_W-1:0] evt_q, evt_n, mask_q, lvl_q, lvl_n;

  // order: source a, source b, then clear
  always_comb begin
    evt_n = evt_q;
    lvl_n = lvl_q;
    if (a_vld_i) begin
      evt_n = (evt_n | a_bits_i) & mask_q;
      lvl_n = a_lvl_i ? (lvl_n | a_bits_i) : (lvl_n & ~a_bits_i);
    end
    if (b_vld_i) begin
      evt_n = (evt_n | b_bits_i) & mask_q;
      lvl_n = b_lvl_i ? (lvl_n | b_bits_i) : (lvl_n & ~b_bits_i);
    end
    if (clr_all_i)     evt_n = '0;
    else if (clr_we_i) evt_n = evt_n & ~clr_bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
    end else begin
      evt_q <= evt_n;
      lvl_q <= lvl_n;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl import irq_evt_pkg::*; #(
  parameter int unsigned DEV_SPLIT = 20,
  parameter int unsigned DMA_SPLIT = 10,
  parameter int unsigned HI_SHIFT  = 10,
  parameter int unsigned MODE_BIT  = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             dev_vld_i,
  input  logic [31:0]      dev_id_i,
  input  logic             dev_lvl_i,
  input  logic             dma_vld_i,
  input  logic [31:0]      dma_id_i,
  input  logic             dma_lvl_i,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] MODE_MASK = REG_W'(1) << MODE_BIT;
  localparam logic [REG_W-1:0] CLR_LIMIT = ~MODE_MASK;

  logic [REG_W-1:0] evt_w  [NBANK];
  logic [REG_W-1:0] mask_w [NBANK];
  logic [REG_W-1:0] lvl_w  [NBANK];

  logic [REG_W-1:0] wsw;
  reg_kind_e        kind;
  logic             rd_bank;
  logic [NBANK-1:0] wr_mask, wr_clr;
  logic             mode, clr_all;

  assign wsw     = bswap32(reg_wdata_i);
  assign kind    = reg_kind_e'(reg_addr_i[3:2]);
  assign rd_bank = ~reg_addr_i[4];   // bank 2 sits at the low offsets
  assign mode    = mask_w[0][MODE_BIT];

  always_comb begin
    wr_mask = '0;
    wr_clr  = '0;
    if (reg_we_i) begin
      if (kind == RK_MASK) wr_mask[rd_bank] = 1'b1;
      if (kind == RK_CLR)  wr_clr[rd_bank]  = 1'b1;
    end
  end

  // clear-all flag is taken from the raw, unswapped word
  assign clr_all = wr_clr[0] & mode & reg_wdata_i[REG_W-1];

  logic [NBANK-1:0]            dev_bv, dma_bv;
  logic [NBANK-1:0][REG_W-1:0] dev_bb, dma_bb;

  irq_src_route #(.SPLIT_LOG2(DEV_SPLIT), .HI_SHIFT(HI_SHIFT)) dev_rt_i (
    .vld_i(dev_vld_i), .id_i(dev_id_i), .bank_vld_o(dev_bv), .bank_bits_o(dev_bb)
  );
  irq_src_route #(.SPLIT_LOG2(DMA_SPLIT), .HI_SHIFT(HI_SHIFT)) dma_rt_i (
    .vld_i(dma_vld_i), .id_i(dma_id_i), .bank_vld_o(dma_bv), .bank_bits_o(dma_bb)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             mask_we;
    logic [REG_W-1:0] mask_d;

    if (b == 0) begin : g_primary
      assign mask_we = wr_mask[0];
      assign mask_d  = wsw;
    end else begin : g_secondary
      // accumulates; mode bit only follows the primary mask
      assign mask_we = wr_mask[0] | wr_mask[b];
      assign mask_d  = wr_mask[0]
                     ? ((mask_w[b] & CLR_LIMIT) | (wsw & MODE_MASK))
                     : (mask_w[b] | (wsw & CLR_LIMIT));
    end

    irq_bank bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .a_vld_i    (dev_bv[b] & mode),
      .a_bits_i   (dev_bb[b]),
      .a_lvl_i    (dev_lvl_i),
      .b_vld_i    (dma_bv[b] & mode),
      .b_bits_i   (dma_bb[b]),
      .b_lvl_i    (dma_lvl_i),
      .mask_we_i  (mask_we),
      .mask_d_i   (mask_d),
      .clr_we_i   (wr_clr[b]),
      .clr_bits_i (wsw & CLR_LIMIT),
      .clr_all_i  (clr_all),
      .evt_o      (evt_w[b]),
      .mask_o     (mask_w[b]),
      .lvl_o      (lvl_w[b])
    );
  end

  always_comb begin
    unique case (kind)
      RK_EVT:  reg_rdata_o = bswap32(evt_w[rd_bank]);
      RK_MASK: reg_rdata_o = bswap32(mask_w[rd_bank]);
      RK_LVL:  reg_rdata_o = bswap32(lvl_w[rd_bank]);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(evt_w[0] | evt_w[1]);
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
module irq_evt_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [4:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_i,
  input logic [31:0] ev1_i,
  input logic [31:0] ev2_i,
  input logic [31:0] mk1_i,
  input logic [31:0] mk2_i
);
  a_r12_irq_tracks_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == |(ev1_i | ev2_i));

  a_r3_mode_mirrored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk2_i[31] == mk1_i[31]);

  a_r4_mask2_accumulates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h04) |=>
      (((mk2_i & $past(mk2_i)) == $past(mk2_i)) && (mk2_i[31] == $past(mk2_i[31]))));

  a_r11_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h18 && mk1_i[31] && wdata_i[31]) |=> (ev1_i == '0 && ev2_i == '0));

  a_r9_idle_without_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mk1_i[31] && !(we_i && (addr_i == 5'h08 || addr_i == 5'h18))) |=>
      ($stable(ev1_i) && $stable(ev2_i)));
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .irq_i   (irq_o),
  .ev1_i   (evt_w[0]),
  .ev2_i   (evt_w[1]),
  .mk1_i   (mask_w[0]),
  .mk2_i   (mask_w[1])
);

// File: tb/irq_evt_ctrl_tb_top.sv
module irq_evt_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        dv = 1'b0, dl = 1'b0, mv = 1'b0, ml = 1'b0;
  logic [31:0] did = '0, mid = '0;
  logic        irq;

  irq_evt_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .dev_vld_i(dv), .dev_id_i(did), .dev_lvl_i(dl),
    .dma_vld_i(mv), .dma_id_i(mid), .dma_lvl_i(ml), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic verify(input string r);
    logic [31:0] d;
    rd(5'h00, d); chk(r, "ev2", d, rev(m_ev[1]));
    rd(5'h04, d); chk(r, "mask2", d, rev(m_mk[1]));
    rd(5'h08, d); chk(r, "clr2", d, 32'h0);
    rd(5'h0C, d); chk(r, "lvl2", d, rev(m_lv[1]));
    rd(5'h10, d); chk(r, "ev1", d, rev(m_ev[0]));
    rd(5'h14, d); chk(r, "mask1", d, rev(m_mk[0]));
    rd(5'h18, d); chk(r, "clr1", d, 32'h0);
    rd(5'h1C, d); chk(r, "lvl1", d, rev(m_lv[0]));
    chk(r, "irq", {31'h0, irq}, {31'h0, |(m_ev[0] | m_ev[1])});
  endtask

  task automatic model_src(input bit is_dma, input logic [31:0] id, input bit lvl);
    int b;
    logic [31:0] bits;
    if (!m_mk[0][31]) return;
    if (id >= (is_dma ? 32'd1024 : 32'd1048576)) begin b = 1; bits = id >> 10; end
    else begin b = 0; bits = id; end
    m_ev[b] = (m_ev[b] | bits) & m_mk[b];
    m_lv[b] = lvl ? (m_lv[b] | bits) : (m_lv[b] & ~bits);
  endtask

  task automatic model_wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] s;
    s = rev(d);
    case (a)
      5'h14: begin m_mk[0] = s; m_mk[1][31] = s[31]; end
      5'h04: m_mk[1] = m_mk[1] | (s & 32'h7FFF_FFFF);
      5'h08: m_ev[1] = m_ev[1] & ~(s & 32'h7FFF_FFFF);
      5'h18: if (m_mk[0][31] && d[31]) begin m_ev[0] = '0; m_ev[1] = '0; end
             else m_ev[0] = m_ev[0] & ~(s & 32'h7FFF_FFFF);
      default: ;
    endcase
  endtask

  // one cycle of stimulus; model applies device, then DMA, then the write
  task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d,
                     input bit dvv, input logic [31:0] dii, input bit dll,
                     input bit mvv, input logic [31:0] mii, input bit mll);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    dv = dvv; did = dii; dl = dll;
    mv = mvv; mid = mii; ml = mll;
    @(negedge clk);
    we = 1'b0; dv = 1'b0; mv = 1'b0;
    if (dvv) model_src(1'b0, dii, dll);
    if (mvv) model_src(1'b1, mii, mll);
    if (w) model_wr(a, d);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic src(input bit is_dma, input logic [31:0] id, input bit lvl);
    if (is_dma) cyc(1'b0, 5'h0, '0, 1'b0, '0, 1'b0, 1'b1, id, lvl);
    else        cyc(1'b0, 5'h0, '0, 1'b1, id, lvl, 1'b0, '0, 1'b0);
  endtask

  task automatic sweep(input bit is_dma);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] id, bits;
      logic [4:0]  ca;
      id = 32'h1 << i;
      src(is_dma, id, 1'b1);
      verify(is_dma ? "R6" : "R5");
      src(is_dma, id, 1'b0);
      verify("R8");
      if (id >= (is_dma ? 32'd1024 : 32'd1048576)) begin bits = id >> 10; ca = 5'h08; end
      else begin bits = id; ca = 5'h18; end
      wr(ca, rev(bits));
      verify(ca == 5'h08 ? "R10" : "R11");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    verify("R1");

    // R9: mode off, notifications ignored
    src(1'b0, 32'h0000_0010, 1'b1);
    src(1'b1, 32'h0000_0800, 1'b1);
    verify("R9");

    // R3 / R2: mask1 with mode bit (raw byte 0 -> reversed byte 3)
    wr(5'h14, 32'h8000_00F0);
    verify("R3");
    // R4: accumulate, mode bit in data ignored for bank 2
    wr(5'h04, 32'h0100_0000);
    wr(5'h04, 32'h0000_0280);
    verify("R4");
    wr(5'h04, 32'hFFFF_FF7F);
    verify("R4");
    // R3: mode copy follows mask1 both ways
    wr(5'h14, 32'h0000_0000);
    verify("R3");
    wr(5'h14, 32'hFFFF_FFFF);
    verify("R2");

    sweep(1'b0);
    sweep(1'b1);

    // R7: shrink mask, next event ANDs the whole bank
    src(1'b0, 32'h0000_00FF, 1'b1);
    src(1'b0, 32'h0000_FF00, 1'b1);
    verify("R7");
    wr(5'h14, rev(32'h8000_0F0F));
    verify("R7");
    src(1'b0, 32'h0001_0000, 1'b1);
    verify("R7");
    wr(5'h14, 32'hFFFF_FFFF);

    // R10: reversed bit 31 only clears nothing
    src(1'b1, 32'hFFFF_FC00, 1'b1);
    wr(5'h08, rev(32'h8000_0000));
    verify("R10");

    // R11: clear with reversed bit 31 but raw bit 31 clear -> no clear-all
    src(1'b0, 32'h0000_0081, 1'b1);
    wr(5'h18, 32'h0000_0080);
    verify("R11");
    // R11: clear-all with mode on
    wr(5'h18, 32'h8000_0000);
    verify("R11");
    verify("R12");

    // R11: mode off, raw bit 31 only clears bank-1 bit 7
    src(1'b0, 32'h0000_0180, 1'b1);
    src(1'b0, 32'h0010_0000, 1'b1);
    wr(5'h14, 32'hFFFF_FF7F);
    wr(5'h18, 32'h8000_0000);
    verify("R11");
    wr(5'h18, 32'hFFFF_FF7F);
    wr(5'h08, 32'hFFFF_FF7F);
    verify("R12");
    wr(5'h14, 32'hFFFF_FFFF);

    // R13: same-cycle update and clear of same bit
    cyc(1'b1, 5'h18, rev(32'h0000_0008), 1'b1, 32'h0000_0008, 1'b1, 1'b0, '0, 1'b0);
    verify("R13");
    // R13: device high, DMA low on same level bit
    cyc(1'b0, 5'h0, '0, 1'b1, 32'h0000_0004, 1'b1, 1'b1, 32'h0000_0004, 1'b0);
    verify("R13");
    // R13: update filtered by pre-write mask
    wr(5'h14, rev(32'h8000_0000));
    cyc(1'b1, 5'h14, 32'hFFFF_FFFF, 1'b1, 32'h0000_0020, 1'b1, 1'b0, '0, 1'b0);
    verify("R13");
    src(1'b1, 32'h0000_0040, 1'b1);
    verify("R12");

    // R1: reset again
    @(negedge clk);
    rst_n = 1'b0;
    for (int b = 0; b < 2; b++) begin m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0; end
    @(negedge clk);
    rst_n = 1'b1;
    verify("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule